// File: doc/BRIEF.md
# Reed-Solomon Sector Parity Engine

This engine snoops a byte-wide flash data bus and keeps a running Reed-Solomon remainder over one sector of data. Each byte is complemented and zero-extended to a 10-bit symbol over GF(2^10) before it enters the remainder. The generator polynomial has six roots, so six 10-bit parity words come out. They are presented as eight packed bytes. A complemented copy of those bytes is also presented, and that copy is what software stores in spare flash. Because of the complement, an erased all-0xFF sector gives an all-0xFF stored code.

On read-back the same engine takes the sector data and then the eight stored code bytes. It forms the six difference words between the recomputed and the stored remainder, and presents them bit-reversed per byte as a syndrome. A flag reports at once whether any difference word is nonzero. Locating and fixing errors is left to software.

A control write with bit 7 set starts a new sector: it clears all state and latches the mode from bit 6. Bit 5 of every control write gates byte capture, so a write of zero freezes the engine.

Top module: `rs_page_ecc`

## Requirements
- R1: After reset, all parity words are zero. `ecc_o` is 0xF000_0000_0000_0000, `ecc_n_o` is all ones, `syn_o` is zero and `chk_o` is zero.
- R2: The parity is the remainder of M(x)·x^6 modulo g(x) = (x+1)(x+α)(x+α^2)(x+α^3)(x+α^4)(x+α^5).
  - The field is GF(2^10) with primitive polynomial x^10+x^3+1 (0x409), and α = x.
  - Each captured byte b enters M(x) as the symbol {2'b00, ~b}, and the first captured byte is the highest-degree coefficient.
  - Word pk is the remainder coefficient of x^k.
- R3: `ecc_o` byte n sits at bits [8n+7:8n]. As a 64-bit value, `ecc_o` equals {4'hF, p0, p1, p2, p3, p4, p5}. This puts p5[7:0] in byte 0 and p0[9:6] in byte 7 bits 3:0, and byte 7 bits 7:4 read as 1.
- R4: `ecc_n_o` is the bitwise complement of `ecc_o` in bits 59:0, and its bits 63:60 read as 1. A sector of all 0xFF bytes therefore gives `ecc_n_o` all ones.
- R5: A control write with bit 7 set clears all state and latches the mode from bit 6 (1 = generate, 0 = check). Every control write loads the capture enable from bit 5. A write with bit 7 clear leaves the parity, the byte count and the mode unchanged.
- R6: A clear takes precedence over a data strobe in the same cycle; that byte is neither counted nor folded into the parity.
- R7: While capture is disabled, data strobes change nothing.
- R8: In generate mode, strobes after SECTOR_BYTES captured bytes are ignored and the parity holds.
- R9: Check mode takes SECTOR_BYTES data bytes and then 8 stored code bytes.
  - `chk_o[7]` is 1 only once all SECTOR_BYTES+8 bytes are in and at least one difference word is nonzero.
  - `chk_o[6:0]` is always 0.
- R10: Difference word sk is pk XOR the stored word k. The stored words are unpacked with the R3 layout from the complement of the stored bytes, so bits 7:4 of stored byte 7 are ignored. `syn_o` is {4'h0, s0..s5}, laid out as in R3, with the bit order of each byte reversed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control value: bit 7 clear, bit 6 generate, bit 5 capture |
| dat_stb | input | 1 | Flash bus byte transfer strobe |
| dat_byte | input | 8 | Flash bus byte |
| ecc_o | output | 64 | Packed parity, byte n at bits [8n+7:8n] |
| ecc_n_o | output | 64 | Complemented packed parity |
| syn_o | output | 64 | Bit-reversed packed difference words |
| chk_o | output | 8 | Bit 7 error flag |

## Verification
The bench uses the default SECTOR_BYTES of 512, so every sector is full length. The remainder is therefore exercised over the real 518-symbol codeword, and the check sequence reaches the exact point where the stored bytes follow the data. At this length a single flipped data byte, a flipped stored code byte and a flip confined to the unused nibble all fall within reach. The bench computes the expected remainder itself by schoolbook polynomial division, with its own field multiply.

// File: rtl/rs_ecc_pkg.sv
package rs_ecc_pkg;
  localparam int SYM_W     = 10;
  localparam int NPAR      = 6;
  localparam int ECC_BYTES = 8;
  localparam int ACC_W     = 2 * SYM_W - 1;
  localparam logic [SYM_W:0] FIELD_POLY = 11'h409;

  typedef logic [SYM_W-1:0] sym_t;
  typedef sym_t [NPAR-1:0] par_t;   // index k = coefficient of x^k
  typedef sym_t [NPAR:0]   gpoly_t;

  // carry-less product followed by reduction, top bit first
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] aw;
    logic [ACC_W-1:0] pw;
    acc = '0;
    aw  = ACC_W'(a);
    pw  = ACC_W'(FIELD_POLY);
    for (int i = 0; i < SYM_W; i++)
      if (b[i]) acc = acc ^ (aw << i);
    for (int j = ACC_W - 1; j >= SYM_W; j--)
      if (acc[j]) acc = acc ^ (pw << (j - SYM_W));
    return acc[SYM_W-1:0];
  endfunction

  // product of (x + alpha^i) for i = 0 .. NPAR-1
  function automatic gpoly_t gen_poly();
    gpoly_t g;
    sym_t   root;
    g    = '0;
    g[0] = sym_t'(1);
    root = sym_t'(1);
    for (int i = 0; i < NPAR; i++) begin
      for (int k = NPAR; k >= 1; k--)
        g[k] = g[k-1] ^ gf_mul(g[k], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, sym_t'(2));
    end
    return g;
  endfunction

  function automatic logic [63:0] pack_words(par_t p, logic [3:0] pad);
    return {pad, p[0], p[1], p[2], p[3], p[4], p[5]};
  endfunction

  function automatic par_t unpack_words(logic [63:0] b);
    par_t p;
    for (int k = 0; k < NPAR; k++)
      p[k] = b[(NPAR-1-k)*SYM_W +: SYM_W];
    return p;
  endfunction

  function automatic logic [63:0] bitrev_bytes(logic [63:0] v);
    logic [63:0] r;
    for (int n = 0; n < ECC_BYTES; n++)
      for (int i = 0; i < 8; i++)
        r[8*n + i] = v[8*n + 7 - i];
    return r;
  endfunction
endpackage

// File: rtl/rs_parity_lfsr.sv
module rs_parity_lfsr
  import rs_ecc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  input  sym_t sym_in,
  output par_t par_o
);
  localparam gpoly_t GEN = gen_poly();

  par_t par_q;
  par_t par_d;
  sym_t fb;

  assign fb = sym_in ^ par_q[NPAR-1];

  for (genvar k = 0; k < NPAR; k++) begin : g_tap
    if (k == 0) begin : g_low
      assign par_d[k] = gf_mul(fb, GEN[k]);
    end else begin : g_mid
      assign par_d[k] = par_q[k-1] ^ gf_mul(fb, GEN[k]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    par_q <= '0;
    else if (clr)  par_q <= '0;
    else if (step) par_q <= par_d;
  end

  assign par_o = par_q;
endmodule

// File: rtl/rs_seq_ctrl.sv
module rs_seq_ctrl
  import rs_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512,
  localparam int TOTAL = SECTOR_BYTES + ECC_BYTES,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [7:0]       ctl_wdata,
  input  logic             dat_stb,
  output logic             clr_now,
  output logic             mode_gen,
  output logic             acc_stb,
  output logic             data_stb,
  output logic             ecc_stb,
  output logic [2:0]       ecc_idx,
  output logic             page_done,
  output logic [CNT_W-1:0] cnt
);
  logic             cap_en;
  logic [CNT_W-1:0] limit;
  logic [4:0]       ctl_unused;

  assign ctl_unused = ctl_wdata[4:0];
  assign clr_now    = ctl_we && ctl_wdata[7];
  assign limit      = mode_gen ? CNT_W'(SECTOR_BYTES) : CNT_W'(TOTAL);
  assign acc_stb    = dat_stb && cap_en && !clr_now && (cnt < limit);
  assign data_stb   = acc_stb && (cnt < CNT_W'(SECTOR_BYTES));
  assign ecc_stb    = acc_stb && !data_stb;
  assign ecc_idx    = 3'(cnt - CNT_W'(SECTOR_BYTES));
  assign page_done  = (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_en   <= 1'b0;
      mode_gen <= 1'b0;
      cnt      <= '0;
    end else begin
      if (ctl_we) cap_en <= ctl_wdata[5];
      if (clr_now) begin
        mode_gen <= ctl_wdata[6];
        cnt      <= '0;
      end else if (acc_stb) begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_rx_capture.sv
module rs_rx_capture
  import rs_ecc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr,
  input  logic [2:0]  idx,
  input  logic [7:0]  byte_in,
  output logic [63:0] rx_o
);
  for (genvar n = 0; n < ECC_BYTES; n++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         lane_q <= '0;
      else if (clr)                       lane_q <= '0;
      else if (wr && idx == 3'(n))        lane_q <= ~byte_in;
    end
    assign rx_o[8*n +: 8] = lane_q;
  end
endmodule

// File: rtl/rs_page_ecc.sv
module rs_page_ecc
  import rs_ecc_pkg::*;
#(
  parameter int SECTOR_BYTES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_we,
  input  logic [7:0]  ctl_wdata,
  input  logic        dat_stb,
  input  logic [7:0]  dat_byte,
  output logic [63:0] ecc_o,
  output logic [63:0] ecc_n_o,
  output logic [63:0] syn_o,
  output logic [7:0]  chk_o
);
  localparam int TOTAL = SECTOR_BYTES + ECC_BYTES;
  localparam int CNT_W = $clog2(TOTAL + 1);

  logic             clr_now;
  logic             mode_gen;
  logic             acc_stb;
  logic             data_stb;
  logic             ecc_stb;
  logic [2:0]       ecc_idx;
  logic             page_done;
  logic [CNT_W-1:0] seq_cnt;
  par_t             calc_par;
  par_t             stored_par;
  par_t             diff_par;
  logic [63:0]      rx_bytes;
  logic             any_diff;
  logic             err_flag;
  sym_t             in_sym;

  assign in_sym = {2'b00, ~dat_byte};

  rs_seq_ctrl #(.SECTOR_BYTES(SECTOR_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_stb(dat_stb), .clr_now(clr_now), .mode_gen(mode_gen),
    .acc_stb(acc_stb), .data_stb(data_stb), .ecc_stb(ecc_stb),
    .ecc_idx(ecc_idx), .page_done(page_done), .cnt(seq_cnt)
  );

  rs_parity_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .clr(clr_now), .step(data_stb),
    .sym_in(in_sym), .par_o(calc_par)
  );

  rs_rx_capture u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr_now), .wr(ecc_stb),
    .idx(ecc_idx), .byte_in(dat_byte), .rx_o(rx_bytes)
  );

  assign stored_par = unpack_words(rx_bytes);
  assign diff_par   = calc_par ^ stored_par;
  assign any_diff   = |diff_par;
  assign err_flag   = !mode_gen && page_done && any_diff;

  assign ecc_o   = pack_words(calc_par, 4'hF);
  assign ecc_n_o = {4'hF, ~ecc_o[59:0]};
  assign syn_o   = bitrev_bytes(pack_words(diff_par, 4'h0));
  assign chk_o   = {err_flag, 7'b0};
endmodule

// File: rtl/rs_page_ecc_chk.sv
module rs_page_ecc_chk #(
  parameter int SECTOR_BYTES = 512,
  localparam int TOTAL = SECTOR_BYTES + 8,
  localparam int CNT_W = $clog2(TOTAL + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctl_we,
  input logic [7:0]       ctl_wdata,
  input logic [63:0]      ecc_o,
  input logic [63:0]      ecc_n_o,
  input logic [63:0]      syn_o,
  input logic [7:0]       chk_o,
  input logic             acc_stb,
  input logic             clr_now,
  input logic             page_done,
  input logic [CNT_W-1:0] cnt
);
  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_we && ctl_wdata[7]) |=> (ecc_n_o == '1 && chk_o == 8'h00));

  a_r10_syn_zero_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_now |=> (syn_o == 64'h0));

  a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_stb && !clr_now) |=> $stable(ecc_o));

  a_r9_flag_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    chk_o[7] |-> page_done);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TOTAL));

  a_r4_complement: assert property (@(posedge clk) disable iff (!rst_n)
    (ecc_n_o[59:0] == ~ecc_o[59:0]) && (ecc_n_o[63:60] == 4'hF) && (ecc_o[63:60] == 4'hF));
endmodule

bind rs_page_ecc rs_page_ecc_chk #(.SECTOR_BYTES(SECTOR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
  .ecc_o(ecc_o), .ecc_n_o(ecc_n_o), .syn_o(syn_o), .chk_o(chk_o),
  .acc_stb(acc_stb), .clr_now(clr_now), .page_done(page_done), .cnt(seq_cnt)
);

// File: tb/tb_rs_page_ecc.sv
module tb_rs_page_ecc;
  localparam int SECTOR = 512;
  localparam int NVEC   = 6;
  // kind[39:36] seed[35:28] step[27:20] flip_idx[19:10] flip_mask[9:2] exp_err[1] pad[0]
  localparam logic [39:0] VEC [NVEC] = '{
    {4'd0, 8'hFF, 8'h00, 10'd0,   8'h00, 1'b0, 1'b0},
    {4'd1, 8'h00, 8'h01, 10'd0,   8'h00, 1'b0, 1'b0},
    {4'd2, 8'hA5, 8'h00, 10'd100, 8'h01, 1'b1, 1'b0},
    {4'd1, 8'h3C, 8'h07, 10'd515, 8'h80, 1'b1, 1'b0},
    {4'd2, 8'h5A, 8'h00, 10'd519, 8'hF0, 1'b0, 1'b0},
    {4'd0, 8'h00, 8'h00, 10'd511, 8'h40, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [7:0]  ctl_wdata = 8'h00;
  logic        dat_stb = 1'b0;
  logic [7:0]  dat_byte = 8'h00;
  logic [63:0] ecc_o, ecc_n_o, syn_o;
  logic [7:0]  chk_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  logic [7:0] page [SECTOR];
  logic [9:0] gcoef [7];

  always #10 clk = ~clk;

  rs_page_ecc #(.SECTOR_BYTES(SECTOR)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .dat_stb(dat_stb), .dat_byte(dat_byte), .ecc_o(ecc_o),
    .ecc_n_o(ecc_n_o), .syn_o(syn_o), .chk_o(chk_o)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [9:0] bmul(input logic [9:0] a_in, input logic [9:0] b_in);
    logic [10:0] a;
    logic [9:0]  b;
    logic [9:0]  r;
    a = {1'b0, a_in}; b = b_in; r = '0;
    for (int i = 0; i < 10; i++) begin
      if (b[0]) r = r ^ a[9:0];
      b = b >> 1;
      a = a << 1;
      if (a[10]) a = a ^ 11'h409;
    end
    return r;
  endfunction

  task automatic build_gen();
    logic [9:0] tmp [7];
    logic [9:0] root;
    for (int k = 0; k < 7; k++) gcoef[k] = '0;
    gcoef[0] = 10'd1;
    root = 10'd1;
    for (int i = 0; i < 6; i++) begin
      for (int k = 0; k < 7; k++)
        tmp[k] = ((k > 0) ? gcoef[k-1] : 10'd0) ^ bmul(gcoef[k], root);
      for (int k = 0; k < 7; k++) gcoef[k] = tmp[k];
      root = bmul(root, 10'd2);
    end
  endtask

  // schoolbook division; returns {r0, r1, ..., r5}
  task automatic model(output logic [59:0] words);
    logic [9:0] cw [SECTOR + 6];
    for (int j = 0; j < SECTOR + 6; j++)
      cw[j] = (j < SECTOR) ? {2'b00, ~page[j]} : 10'd0;
    for (int j = 0; j < SECTOR; j++) begin
      logic [9:0] q;
      q = cw[j];
      if (q != 0)
        for (int k = 1; k <= 6; k++)
          cw[j+k] = cw[j+k] ^ bmul(q, gcoef[6-k]);
    end
    for (int k = 0; k < 6; k++)
      words[59 - 10*k -: 10] = cw[SECTOR + 5 - k];
  endtask

  function automatic logic [63:0] rev8(input logic [63:0] v);
    logic [63:0] r;
    for (int n = 0; n < 8; n++)
      for (int i = 0; i < 8; i++)
        r[8*n+i] = v[8*n+7-i];
    return r;
  endfunction

  function automatic logic [7:0] pat(input logic [3:0] kind, input logic [7:0] seed,
                                     input logic [7:0] step, input int i);
    logic [7:0] iv;
    iv = i[7:0];
    case (kind)
      4'd1:    return seed + iv * step;
      4'd2:    return iv ^ seed ^ 8'(i >> 8);
      default: return seed;
    endcase
  endfunction

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk);
    dat_stb = 1'b1; dat_byte = b;
    @(negedge clk);
    dat_stb = 1'b0;
  endtask

  task automatic stream_page();
    for (int i = 0; i < SECTOR; i++) strobe(page[i]);
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [59:0] w, w2;
    logic [63:0] exp_ecc, exp_n, stored, inv, syn_exp, hold;
    build_gen();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check64("R1 ecc_o", ecc_o, 64'hF000_0000_0000_0000);
    check64("R1 ecc_n_o", ecc_n_o, '1);
    check64("R1 syn_o", syn_o, 64'h0);
    check64("R1 chk_o", {56'h0, chk_o}, 64'h0);

    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] kind;
      logic [7:0] seed, step, mask;
      logic [9:0] fidx;
      logic       eerr;
      kind = VEC[v][39:36]; seed = VEC[v][35:28]; step = VEC[v][27:20];
      fidx = VEC[v][19:10]; mask = VEC[v][9:2];   eerr = VEC[v][1];
      for (int i = 0; i < SECTOR; i++) page[i] = pat(kind, seed, step, i);
      model(w);
      exp_ecc = {4'hF, w};
      exp_n   = {4'hF, ~w};
      wr_ctl(8'hE0);
      stream_page();
      check64("R2 R3 generated parity", ecc_o, exp_ecc);
      check64("R4 complemented parity", ecc_n_o, exp_n);
      check64("R9 no flag in generate", {56'h0, chk_o}, 64'h0);
      if (kind == 4'd0 && seed == 8'hFF)
        check64("R4 blank sector", ecc_n_o, '1);

      // read check
      if (fidx < 10'(SECTOR)) page[fidx] = page[fidx] ^ mask;
      model(w2);
      stored = exp_n;
      if (fidx >= 10'(SECTOR)) stored[8*(fidx - 10'(SECTOR)) +: 8] = stored[8*(fidx - 10'(SECTOR)) +: 8] ^ mask;
      wr_ctl(8'hA0);
      stream_page();
      check64("R9 no flag before code bytes", {56'h0, chk_o}, 64'h0);
      for (int n = 0; n < 8; n++) strobe(stored[8*n +: 8]);
      check64("R9 error flag", {56'h0, chk_o}, {56'h0, eerr, 7'b0});
      inv = ~stored;
      syn_exp = rev8({4'h0, w2 ^ inv[59:0]});
      check64("R10 syndrome", syn_o, syn_exp);
    end

    // R7: capture disabled
    wr_ctl(8'hC0);
    for (int i = 0; i < 5; i++) strobe(8'h12);
    check64("R7 strobes ignored while frozen", ecc_o, 64'hF000_0000_0000_0000);

    // R5: enable-only write keeps mode and state
    for (int i = 0; i < SECTOR; i++) page[i] = pat(4'd1, 8'h11, 8'h03, i);
    model(w);
    wr_ctl(8'h20);
    stream_page();
    check64("R5 enable-only write", ecc_o, {4'hF, w});

    // R8: extra strobes after full sector in generate mode
    hold = ecc_o;
    for (int i = 0; i < 3; i++) strobe(8'h00);
    check64("R8 parity holds after sector", ecc_o, hold);

    // R7: freeze with a zero write in mid-sector
    wr_ctl(8'hE0);
    for (int i = 0; i < 100; i++) strobe(page[i]);
    hold = ecc_o;
    wr_ctl(8'h00);
    for (int i = 0; i < 4; i++) strobe(8'h5A);
    check64("R7 zero write freezes", ecc_o, hold);

    // R6: clear and strobe in the same cycle
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = 8'hE0; dat_stb = 1'b1; dat_byte = 8'h00;
    @(negedge clk);
    ctl_we = 1'b0; dat_stb = 1'b0;
    check64("R6 clear wins", ecc_o, 64'hF000_0000_0000_0000);
    stream_page();
    check64("R6 simultaneous byte not counted", ecc_o, {4'hF, w});

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule